// File: doc/BRIEF.md
# Dual-Channel Overflow Flag Generator

This block turns over-range events from a left and a right sample path into one active-low overflow line. That line shares its timing with a serial audio frame. Each channel keeps its own "overflowed" status, which is set in the clock cycle that follows an over-range event. A single hold-off timer, counted in frame periods, decides when both statuses clear again. Any new event on either side reloads that timer, so the two channels are released together, and only after the line has been quiet for the whole hold-off.

The line carries the left status during the left half of the frame and the right status during the right half. A receiver can therefore separate the two by latching on the frame-clock edges. The output changes only at an update point a fixed number of bit-clock falling edges after each frame-clock transition: one in left-justified format and two in I2S format. The format is captured while reset is asserted. All inputs are taken to be synchronous to the system clock. The bit clock and the frame clock pass through a short synchronising chain before their edges are detected.

Top module: `ovf_mux_flag`

## Requirements
- R1: While reset is asserted and after its release, `ovf_n` is 1 (no overflow) until an update point carries a set status.
- R2: A one-cycle pulse on `ovr_left` sets the left status on the next clock, and every following left slot drives `ovf_n` to 0.
- R3: A pulse on `ovr_right` sets only the right status. Slots of the other channel stay at 1 unless that channel has its own event.
- R4: Both statuses clear together when the hold-off counter reaches zero. The counter is loaded with `HOLD_FRAMES` and steps down by one on each rising frame-clock edge. At zero it stays at zero.
- R5: An event on either channel reloads the shared counter, which extends the low period of a channel flagged earlier.
- R6: With format 0 (left-justified), `ovf_n` updates on the first bit-clock falling edge after a frame-clock transition. The frame clock high selects the left status and low selects the right.
- R7: With format 1 (I2S), `ovf_n` updates on the second bit-clock falling edge after a frame-clock transition. The frame clock low selects the left status and high selects the right.
- R8: `fmt_sel` is captured only while reset is asserted. Changing it during operation has no effect on slot timing or channel order.
- R9: `ovf_n` holds its value between update points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures `fmt_sel` |
| fmt_sel | input | 1 | Serial format: 0 left-justified, 1 I2S |
| bclk | input | 1 | Serial bit clock, sampled by `clk` |
| fclk | input | 1 | Serial frame clock, sampled by `clk` |
| ovr_left | input | 1 | Left over-range event, active high |
| ovr_right | input | 1 | Right over-range event, active high |
| ovf_n | output | 1 | Multiplexed overflow flag, active low |

## Verification
A hold-off counter that is off by one shows up as a left or right slot that stays low one frame too long or releases one frame too early. Because restarts are shared, the bench places events on both channels a few frames apart so that a counter reloaded per channel shows up as an early release. A slot counter or format latch in the wrong state moves the pin change by a whole bit period, 8 system clocks in the bench, or swaps the channel order. Both faults appear within the first slot after an event. The bench probes the pin between the one- and two-bit update points of every slot to catch them.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef struct packed {
        logic left;
        logic right;
    } chan_pair_t;

    localparam int unsigned SLOT_CNT_W = 2;

    // Number of bit-clock falling edges between a frame edge and the update.
    function automatic logic [SLOT_CNT_W-1:0] slot_delay(fmt_e f);
        return (f == FMT_I2S) ? SLOT_CNT_W'(2) : SLOT_CNT_W'(1);
    endfunction

    // Whether the current frame-clock level marks the left half.
    function automatic logic slot_is_left(fmt_e f, logic lvl);
        return (f == FMT_LJ) ? lvl : ~lvl;
    endfunction

    function automatic logic pick_status(chan_pair_t s, logic take_left);
        return take_left ? s.left : s.right;
    endfunction

endpackage

// File: rtl/ovf_edge_sync.sv
module ovf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], din};
    end

    assign lvl  = shreg[STAGES-1];
    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
    assign fall = ~shreg[STAGES-1] & shreg[STAGES];
endmodule

// File: rtl/ovf_holdoff.sv
module ovf_holdoff
    import ovf_pkg::*;
#(
    parameter int HOLD_FRAMES = 2048,
    parameter int TW          = $clog2(HOLD_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_pair_t    event_in,
    input  logic          frame_tick,
    output chan_pair_t    status,
    output logic [TW-1:0] timer
);
    localparam logic [TW-1:0] RELOAD = TW'(HOLD_FRAMES);
    localparam logic [TW-1:0] ONE    = TW'(1);

    logic any_event;
    assign any_event = event_in.left | event_in.right;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer  <= '0;
            status <= '0;
        end else if (any_event) begin
            timer  <= RELOAD;
            status <= status | event_in;
        end else if (frame_tick && timer != '0) begin
            timer <= timer - ONE;
            if (timer == ONE) status <= '0;
        end
    end
endmodule

// File: rtl/ovf_slot_mux.sv
module ovf_slot_mux
    import ovf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_e       fmt,
    input  logic       bit_fall,
    input  logic       frame_edge,
    input  logic       frame_lvl,
    input  chan_pair_t status,
    output logic       upd,
    output logic       ovf_n
);
    logic [SLOT_CNT_W-1:0] cnt;
    logic [SLOT_CNT_W-1:0] cnt_nxt;
    logic                  armed;
    logic                  hit;

    assign cnt_nxt = cnt + SLOT_CNT_W'(1);
    assign hit     = (cnt_nxt == slot_delay(fmt));
    assign upd     = armed & bit_fall & ~frame_edge & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (frame_edge) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (armed && bit_fall) begin
            cnt <= cnt_nxt;
            if (hit) armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      ovf_n <= 1'b1;
        else if (upd) ovf_n <= ~pick_status(status, slot_is_left(fmt, frame_lvl));
    end
endmodule

// File: rtl/ovf_mux_flag.sv
module ovf_mux_flag
    import ovf_pkg::*;
#(
    parameter int HOLD_FRAMES = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fmt_sel,
    input  logic bclk,
    input  logic fclk,
    input  logic ovr_left,
    input  logic ovr_right,
    output logic ovf_n
);
    localparam int TW = $clog2(HOLD_FRAMES + 1);

    fmt_e          fmt_q;
    logic          b_lvl, b_rise, b_fall;
    logic          f_lvl, f_rise, f_fall;
    chan_pair_t    events;
    chan_pair_t    status;
    logic [TW-1:0] timer;
    logic          upd_strobe;

    always_ff @(posedge clk) begin
        if (rst) fmt_q <= fmt_e'(fmt_sel);
    end

    assign events = '{left: ovr_left, right: ovr_right};

    ovf_edge_sync #(.STAGES(SYNC_STAGES)) u_bsync (
        .clk(clk), .rst(rst), .din(bclk),
        .lvl(b_lvl), .rise(b_rise), .fall(b_fall)
    );

    ovf_edge_sync #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst(rst), .din(fclk),
        .lvl(f_lvl), .rise(f_rise), .fall(f_fall)
    );

    ovf_holdoff #(.HOLD_FRAMES(HOLD_FRAMES), .TW(TW)) u_hold (
        .clk(clk), .rst(rst), .event_in(events), .frame_tick(f_rise),
        .status(status), .timer(timer)
    );

    ovf_slot_mux u_slot (
        .clk(clk), .rst(rst), .fmt(fmt_q), .bit_fall(b_fall),
        .frame_edge(f_rise | f_fall), .frame_lvl(f_lvl), .status(status),
        .upd(upd_strobe), .ovf_n(ovf_n)
    );

    logic unused_ok;
    assign unused_ok = b_lvl ^ b_rise;
endmodule

// File: rtl/ovf_mux_flag_chk.sv
module ovf_mux_flag_chk
    import ovf_pkg::*;
#(
    parameter int HOLD_FRAMES = 2048,
    parameter int TW          = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          ovr_l,
    input logic          ovr_r,
    input chan_pair_t    stat,
    input logic [TW-1:0] timer,
    input logic          upd,
    input logic          ovf_n,
    input fmt_e          fmt_q
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ovf_n);

    p_left_set_r2: assert property (@(posedge clk) disable iff (rst)
        ovr_l |=> stat.left);

    p_right_set_r3: assert property (@(posedge clk) disable iff (rst)
        ovr_r |=> stat.right);

    p_clear_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (timer == '0) |-> (stat == '0));

    p_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (timer == '0 && !ovr_l && !ovr_r) |=> (timer == '0));

    p_shared_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (ovr_l || ovr_r) |=> (timer == TW'(HOLD_FRAMES)));

    p_fmt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(fmt_q));

    p_pin_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(ovf_n));
endmodule

bind ovf_mux_flag ovf_mux_flag_chk #(.HOLD_FRAMES(HOLD_FRAMES), .TW(TW)) u_chk (
    .clk(clk), .rst(rst), .ovr_l(ovr_left), .ovr_r(ovr_right),
    .stat(status), .timer(timer), .upd(upd_strobe), .ovf_n(ovf_n),
    .fmt_q(fmt_q)
);

// File: tb/test_ovf_mux_flag.sv
`timescale 1ns/1ps
module test_ovf_mux_flag;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fmt_sel = 1'b0;
    logic bclk = 1'b0;
    logic fclk = 1'b0;
    logic ovr_l = 1'b0;
    logic ovr_r = 1'b0;
    logic ovf_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_cnt = 0;
    bit m_l = 0, m_r = 0;
    bit m_fmt = 0;
    bit last_exp = 1;

    bit    exp_q[$];
    string tag_q[$];
    event  smp_ev;

    always #2.5 clk = ~clk;

    ovf_mux_flag #(.HOLD_FRAMES(HOLD)) i_ovf_mux_flag (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .bclk(bclk), .fclk(fclk),
        .ovr_left(ovr_l), .ovr_right(ovr_r), .ovf_n(ovf_n)
    );

    task automatic chk(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ovf_n=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor: compares the pin at mid-slot with the queued expectation
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                chk(ovf_n, 1'b0, "scoreboard empty");
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(ovf_n, e, t);
            end
        end
    end

    task automatic reset_dut(bit f);
        @(negedge clk);
        rst = 1; fmt_sel = f; fclk = 0; bclk = 0; ovr_l = 0; ovr_r = 0;
        repeat (4) @(negedge clk);
        chk(ovf_n, 1'b1, "R1 high during reset");
        rst = 0;
        m_fmt = f; m_cnt = 0; m_l = 0; m_r = 0; last_exp = 1;
        exp_q.delete(); tag_q.delete();
        @(negedge clk);
        chk(ovf_n, 1'b1, "R1 high after reset");
    endtask

    // one half-frame: 16 bit periods of 8 system clocks
    task automatic run_slot(bit il, bit ir, string tag);
        bit left, e;
        string dtag;
        @(negedge clk);
        fclk = ~fclk;
        bclk = 0;
        if (fclk && m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin m_l = 0; m_r = 0; end
        end
        left = (m_fmt == 0) ? fclk : !fclk;
        e    = !(left ? m_l : m_r);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        dtag = m_fmt ? "R7 two-bit update (I2S)" : "R6 one-bit update (LJ)";
        for (int t = 1; t < 128; t++) begin
            @(negedge clk);
            bclk = ((t % 8) >= 4);
            if (t == 13) chk(ovf_n, m_fmt ? last_exp : e, dtag);
            if (t == 21) chk(ovf_n, e, dtag);
            if (t == 40) ->smp_ev;
            if (t == 64) begin
                ovr_l = il; ovr_r = ir;
                if (il || ir) begin
                    m_l = m_l | il; m_r = m_r | ir; m_cnt = HOLD;
                end
            end
            if (t == 65) begin ovr_l = 0; ovr_r = 0; end
            if (t == 100) chk(ovf_n, e, "R9 hold between updates");
        end
        last_exp = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        // left-justified
        reset_dut(1'b0);
        repeat (4) run_slot(0, 0, "R1 idle slots high");
        run_slot(1, 0, "R2 left event");
        repeat (11) run_slot(0, 0, "R2 R4 R6 left low then release");
        run_slot(0, 1, "R3 right event");
        repeat (4) run_slot(0, 0, "R3 right only");
        run_slot(1, 0, "R5 left event restarts shared timer");
        repeat (12) run_slot(0, 0, "R4 R5 both held then released");
        fmt_sel = 1'b1;
        run_slot(1, 0, "R8 format change ignored");
        repeat (9) run_slot(0, 0, "R8 LJ timing kept");
        // I2S
        reset_dut(1'b1);
        repeat (3) run_slot(0, 0, "R1 idle slots high I2S");
        run_slot(0, 1, "R3 right event I2S");
        repeat (11) run_slot(0, 0, "R3 R7 right low then release");
        run_slot(1, 1, "R2 both events I2S");
        repeat (3) run_slot(0, 0, "R7 both low");
        run_slot(0, 1, "R5 right restarts left too");
        repeat (12) run_slot(0, 0, "R4 R5 release after restart");
        fmt_sel = 1'b0;
        repeat (4) run_slot(0, 0, "R8 I2S timing kept");
        done = 1;
        summary();
    end
endmodule